// File: doc/BRIEF.md
# Serial Peripheral Control Front End with Guarded Soft Reset

This block is the control-word front end of a serial peripheral. It holds the peripheral's global enable bit, which also serves as the request to the clock gate that feeds the peripheral's internal logic. It watches a 2-bit command field in the same control word. When software writes a guarded two-step command, the block issues a soft-reset pulse that clears the peripheral's transfer, interrupt, DMA, status and error state. Baud-rate, frame-format and data settings are not touched by that pulse.

The control word sits at one address of a simple register bus. Any read or write to a different address of the peripheral counts as an access to another register and voids a half-entered command. The command is accepted only while the enable bit is set and no soft reset is already running. A hardware reset clears the enable bit, drops any half-entered command and holds every clear line high for as long as reset lasts. The bus has no back-pressure: every access completes in the cycle it is presented, and reads return data in that same cycle.

Top module: `periph_ctrl_front`

## Requirements
- R1: While hardware reset is asserted, `en_o`, `srst_o` and `busy_o` are 0, every bit of `clr_o` is 1 and `rdata_o` is 0.
- R2: A write to the control address stores wdata bit 0 as the enable bit. `en_o` shows it from the next cycle on. A read of the control address returns the enable bit at bit 0 and zero in every other bit, including the command field at bits 7:6.
- R3: While enabled, writing command 2'b10 at bits 7:6 and then command 2'b01 raises `srst_o` and `busy_o` for exactly two cycles, starting in the cycle after the 01 write. Every `clr_o` bit is high during those cycles.
- R4: A read or write to any address other than the control address, made between the 10 write and the 01 write, cancels the command, and the following 01 produces no pulse.
- R5: A command write of 00 or 11 between 10 and 01 cancels the sequence. A repeated 10 keeps it armed, so 10, 10, 01 produces a pulse.
- R6: A 01 write that does not follow an armed 10 produces no pulse.
- R7: The enable value held before a write decides whether that write takes part in the sequence. While that value is 0, neither 10 nor 01 has any effect and no pulse is produced.
- R8: The enable bit keeps its value through a soft reset.
- R9: Writes made while `busy_o` is high are accepted, so an enable written then reads back. Their command field is ignored: a 10 written then does not arm a later 01.
- R10: A read of the control address between 10 and 01 does not cancel the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| addr_i | input | ADDR_W | Register bus address |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle of `rd_i` |
| en_o | output | 1 | Enable bit, used as clock-gate request |
| srst_o | output | 1 | Soft-reset pulse to downstream logic |
| busy_o | output | 1 | Soft reset in progress |
| clr_o | output | N_CLR | Per-group clear lines: transfer enable, interrupt setup, DMA enables, status, error flags |

## Verification
The bench builds the block with its default parameters: control word at address 0, a two-cycle pulse and five clear groups. These defaults bring the exact two-cycle pulse width into reach, along with overlap cases where a new command arrives while that pulse is still high. The scoreboard predicts the cycle in which each pulse must start. Every cancelling pattern, whether a foreign read, a foreign write, a 00 or 11 command, entry while disabled or entry while busy, must produce no extra rising edge. A missing or extra pulse shows up as a mismatch or as a non-empty queue at the end.

// File: rtl/pcf_pkg.sv
`timescale 1ns/1ps
package pcf_pkg;
  typedef enum logic [1:0] {
    CMD_CANCEL0 = 2'b00,
    CMD_FIRE    = 2'b01,
    CMD_ARM     = 2'b10,
    CMD_CANCEL3 = 2'b11
  } srst_cmd_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pcf_regs.sv
`timescale 1ns/1ps
module pcf_regs #(
  parameter int DATA_W = 32,
  parameter int EN_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_rd_i,
  input  logic              wr_en_bit_i,
  output logic              en_q_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (ctrl_wr_i) en_q <= wr_en_bit_i;
  end

  // Only the enable bit is readable; the command field is write-only.
  always_comb begin
    rdata_o = '0;
    if (ctrl_rd_i) rdata_o[EN_BIT] = en_q;
  end

  assign en_q_o = en_q;
endmodule

// File: rtl/pcf_unlock.sv
`timescale 1ns/1ps
module pcf_unlock
  import pcf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_q_i,
  input  logic       busy_i,
  input  logic       ctrl_wr_i,
  input  logic [1:0] cmd_i,
  input  logic       other_acc_i,
  output logic       fire_o
);
  seq_state_e state_q, state_d;
  srst_cmd_e  cmd;
  logic       live;

  assign cmd  = srst_cmd_e'(cmd_i);
  assign live = en_q_i && !busy_i;

  always_comb begin
    state_d = state_q;
    fire_o  = 1'b0;
    if (!live || other_acc_i) begin
      state_d = SEQ_IDLE;
    end else if (ctrl_wr_i) begin
      unique case (cmd)
        CMD_ARM:  state_d = SEQ_ARMED;
        CMD_FIRE: begin
          fire_o  = (state_q == SEQ_ARMED);
          state_d = SEQ_IDLE;
        end
        default:  state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/pcf_pulse.sv
`timescale 1ns/1ps
module pcf_pulse #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (fire_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/periph_ctrl_front.sv
`timescale 1ns/1ps
module periph_ctrl_front #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int CTRL_ADDR    = 0,
  parameter int EN_BIT       = 0,
  parameter int CMD_LSB      = 6,
  parameter int PULSE_CYCLES = 2,
  parameter int N_CLR        = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              srst_o,
  output logic              busy_o,
  output logic [N_CLR-1:0]  clr_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic hit, ctrl_wr, ctrl_rd, other_acc;
  logic en_q, fire, active;

  assign hit       = (addr_i == CTRL_A);
  assign ctrl_wr   = wr_i && hit;
  assign ctrl_rd   = rd_i && hit;
  assign other_acc = (wr_i || rd_i) && !hit;

  pcf_regs #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_rd_i   (ctrl_rd),
    .wr_en_bit_i (wdata_i[EN_BIT]),
    .en_q_o      (en_q),
    .rdata_o     (rdata_o)
  );

  pcf_unlock u_unlock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_q_i      (en_q),
    .busy_i      (active),
    .ctrl_wr_i   (ctrl_wr),
    .cmd_i       (wdata_i[CMD_LSB +: 2]),
    .other_acc_i (other_acc),
    .fire_o      (fire)
  );

  pcf_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .active_o (active)
  );

  assign en_o   = en_q;
  assign srst_o = active;
  assign busy_o = active;

  // Each clear group follows the soft pulse and the hardware reset.
  for (genvar g = 0; g < N_CLR; g++) begin : g_clr
    assign clr_o[g] = active || !rst_ni;
  end
endmodule

// File: rtl/pcf_checker.sv
`timescale 1ns/1ps
module pcf_checker #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int CTRL_ADDR    = 0,
  parameter int EN_BIT       = 0,
  parameter int CMD_LSB      = 6,
  parameter int PULSE_CYCLES = 2,
  parameter int N_CLR        = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              en_o,
  input logic              srst_o,
  input logic [N_CLR-1:0]  clr_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam int RUN_W = $clog2(PULSE_CYCLES + 2);

  logic [RUN_W-1:0] run_q;
  logic ctrl_wr;
  assign ctrl_wr = wr_i && (addr_i == CTRL_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (srst_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R3: pulse never exceeds its width
  a_r3_width_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |-> (run_q < RUN_W'(PULSE_CYCLES)));

  // R3: pulse never ends early
  a_r3_width_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(srst_o) |-> ($past(run_q) == RUN_W'(PULSE_CYCLES - 1)));

  // R3: a pulse starts only after a 01 command write
  a_r3_fire_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srst_o) |-> $past(ctrl_wr && wdata_i[CMD_LSB +: 2] == 2'b01));

  // R3: all clear lines high during the pulse
  a_r3_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |-> (&clr_o));

  // R7: no pulse starts while disabled
  a_r7_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srst_o) |-> $past(en_o));

  // R8: enable held through a soft reset unless written
  a_r8_enable_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_o && !ctrl_wr) |=> $stable(en_o));

  // R2: only the enable bit can ever read non-zero
  a_r2_read_zeros: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~(DATA_W'(1) << EN_BIT)) == '0);
endmodule

bind periph_ctrl_front pcf_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .EN_BIT(EN_BIT),
  .CMD_LSB(CMD_LSB), .PULSE_CYCLES(PULSE_CYCLES), .N_CLR(N_CLR)
) u_pcf_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .en_o(en_o), .srst_o(srst_o),
  .clr_o(clr_o)
);

// File: tb/periph_ctrl_front_bench.sv
`timescale 1ns/1ps
module periph_ctrl_front_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PULSE  = 2;
  localparam int N_CLR  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              en, srst, busy;
  logic [N_CLR-1:0]  clr;

  int errors = 0, checks = 0, cyc = 0;
  int exp_q[$];
  logic mon_on = 1'b0;

  periph_ctrl_front u_periph_ctrl_front (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .en_o(en), .srst_o(srst),
    .busy_o(busy), .clr_o(clr)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one control write; push the expected pulse start when it fires.
  task automatic ctrl_write(input logic en_b, input logic [1:0] cmd, input bit fires);
    @(negedge clk);
    addr = '0; wr = 1'b1; rd = 1'b0;
    wdata = '0; wdata[0] = en_b; wdata[7:6] = cmd;
    if (fires) exp_q.push_back(cyc + 1);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic other_access(input logic [ADDR_W-1:0] a, input bit is_wr);
    @(negedge clk);
    addr = a; wr = is_wr; rd = !is_wr; wdata = '1;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; addr = '0;
  endtask

  task automatic ctrl_read(input string req, input int exp_val);
    @(negedge clk);
    addr = '0; rd = 1'b1; wr = 1'b0;
    #0.5;
    check(req, int'(rdata), exp_val);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compare each pulse start and width with the scoreboard.
  initial begin
    int run = 0;
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (srst && !prev) begin
          if (exp_q.size() == 0) check("R3 unexpected pulse at cycle", cyc, -1);
          else check("R3 pulse start cycle", cyc, exp_q.pop_front());
          check("R3 busy with pulse", int'(busy), 1);
          check("R3 clear lines", int'(clr), (1 << N_CLR) - 1);
        end
        if (srst) run++;
        if (!srst && prev) begin
          check("R3 pulse width", run, PULSE);
          run = 0;
        end
        prev = srst;
      end
    end
  end

  initial begin
    #(200000 * 5);
    check("watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    check("R1 en", int'(en), 0);
    check("R1 srst", int'(srst), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 clr", int'(clr), (1 << N_CLR) - 1);
    check("R1 rdata", int'(rdata), 0);
    @(negedge clk); rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R2: enable write and readback; command bits read as zero
    ctrl_write(1'b1, 2'b11, 0);
    check("R2 en_o", int'(en), 1);
    ctrl_read("R2 readback", 1);

    // R3: basic sequence
    ctrl_write(1'b1, 2'b10, 0);
    ctrl_write(1'b1, 2'b01, 1);
    idle(4);
    // R8: enable survives
    ctrl_read("R8 enable kept", 1);
    check("R8 en_o", int'(en), 1);

    // R4: foreign read and foreign write cancel
    ctrl_write(1'b1, 2'b10, 0);
    other_access(8'h04, 0);
    ctrl_write(1'b1, 2'b01, 0);
    ctrl_write(1'b1, 2'b10, 0);
    other_access(8'h08, 1);
    ctrl_write(1'b1, 2'b01, 0);
    idle(4);
    check("R4 nothing pending", exp_q.size(), 0);

    // R5: 00 and 11 cancel; repeated 10 keeps arm
    ctrl_write(1'b1, 2'b10, 0);
    ctrl_write(1'b1, 2'b00, 0);
    ctrl_write(1'b1, 2'b01, 0);
    ctrl_write(1'b1, 2'b10, 0);
    ctrl_write(1'b1, 2'b11, 0);
    ctrl_write(1'b1, 2'b01, 0);
    ctrl_write(1'b1, 2'b10, 0);
    ctrl_write(1'b1, 2'b10, 0);
    ctrl_write(1'b1, 2'b01, 1);
    idle(4);

    // R6: lone 01
    ctrl_write(1'b1, 2'b01, 0);
    idle(4);
    check("R6 nothing pending", exp_q.size(), 0);

    // R10: own read in between keeps sequence
    ctrl_write(1'b1, 2'b10, 0);
    ctrl_read("R10 read between", 1);
    ctrl_write(1'b1, 2'b01, 1);
    idle(4);

    // R9: 10 during pulse does not arm; enable write accepted
    ctrl_write(1'b1, 2'b10, 0);
    ctrl_write(1'b1, 2'b01, 1);
    ctrl_write(1'b0, 2'b10, 0);
    ctrl_read("R9 enable written while busy", 0);
    ctrl_write(1'b1, 2'b00, 0);
    ctrl_write(1'b1, 2'b01, 0);
    idle(4);
    check("R9 nothing pending", exp_q.size(), 0);

    // R7: disabled, and entry begun while disabled
    ctrl_write(1'b0, 2'b00, 0);
    check("R7 en_o low", int'(en), 0);
    ctrl_write(1'b0, 2'b10, 0);
    ctrl_write(1'b0, 2'b01, 0);
    ctrl_write(1'b1, 2'b10, 0);
    ctrl_write(1'b1, 2'b01, 0);
    idle(4);
    check("R7 nothing pending", exp_q.size(), 0);
    check("R3 srst low at end", int'(srst), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule